// File: doc/BRIEF.md
# Direct-Mapped L2 Tag Controller

This block keeps the tag state of a direct-mapped secondary cache with 32-byte lines and decides, for each CPU access, whether the line is present, whether it holds modified data, and whether an evicted line has to be written back first. A request is one physical address with a read or write flag. One cycle later the block returns hit, the dirty status of the indexed line and, on a read miss that evicts a modified line, a writeback request that carries the victim's line address.

The tag is always 10 bits wide. The number of lines follows a size code, so the index field grows with the size and the tag field moves up in the address. The smallest nonzero size has `2**MIN_IDX_W` lines and each higher code doubles it. With `MIN_IDX_W = 13` the codes give 256 KB, 512 KB, 1 MB and 2 MB. The default of 5 keeps the tag store small. Size code 0 turns the cache off. A programmable upper bound limits which addresses can be cached. Two firmware windows, a system one and a video one, can each be made read-only in the cache. The block runs in write-back or write-through mode. The configuration inputs are static while requests flow, and a change of size is preceded by a reset.

Top module: `l2t_ctrl`

## Requirements
- R1: After reset every line is invalid. `rsp_valid`, `rsp_hit`, `wb_req` and `wb_addr` are 0, and the first read of any address misses.
- R2: A request sampled at a clock edge produces `rsp_valid` = 1 right after that edge. A cycle without a request gives `rsp_valid` = 0, `rsp_hit` = 0 and `wb_req` = 0.
- R3: Bits [4:0] of the address are the byte offset. The index is the next `MIN_IDX_W + code - 1` bits. The tag is the 10 bits directly above the index, and address bits above the tag are ignored. A hit requires the indexed line to be valid with an equal tag.
- R4: Size codes 1 to 4 select `2**(MIN_IDX_W+code-1)` lines. Codes 0 and 5 to 7 disable the cache: no hit, no allocation, no writeback, and `rsp_dirty` = 0.
- R5: An address at or above `cfg_limit` is uncacheable. It never hits, never allocates and never raises `wb_req`.
- R6: A cacheable read miss allocates the line with the new tag, valid and clean, so the next read of that line hits.
- R7: A read miss whose indexed line is valid and dirty raises `wb_req`, and `wb_addr` = victim tag and index placed at their bit positions, with offset and higher bits 0. `wb_req` is never set by a write, and `wb_addr` is 0 whenever `wb_req` is 0.
- R8: In write-back mode (`cfg_wb` = 1) a write hit to an unprotected address marks the line dirty.
- R9: In write-through mode (`cfg_wb` = 0) a write hit leaves the line clean, so a later eviction raises no writeback.
- R10: A write miss changes no line in either mode.
- R11: `cfg_bios_wp[0]` protects `0xF0000`-`0xFFFFF` and `cfg_bios_wp[1]` protects `0xC0000`-`0xC7FFF`. A write hit in an enabled window leaves the line unchanged. Reads there allocate as usual.
- R12: `rsp_dirty` reports the valid-and-dirty state of the indexed line before this access updates it, whatever the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Physical byte address |
| cfg_size | input | 3 | Size code, 0 = off, 1..4 = sizes |
| cfg_wb | input | 1 | 1 = write-back, 0 = write-through |
| cfg_limit | input | ADDR_W | Exclusive upper bound of the cacheable space |
| cfg_bios_wp | input | 2 | Bit 0 system window, bit 1 video window read-only |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | Tag matched on a valid, cacheable line |
| rsp_dirty | output | 1 | Indexed line was valid and dirty |
| wb_req | output | 1 | Victim line has to be written back |
| wb_addr | output | ADDR_W | Line address of the victim |

## Verification
In one cycle a read miss both evicts a dirty line, which reports the old tag through `wb_addr`, and installs the new tag in the same entry. The bench provokes this by marking a line dirty with a write hit and then reading a conflicting address. It judges the result by the exact victim address, by `rsp_dirty` being 1 in that response, and by a following read of the new address hitting clean. A write hit inside a protected firmware window also meets the dirty-marking path in the same cycle, and the bench judges that case from the dirty status reported by the next read.

// File: rtl/l2t_pkg.sv
package l2t_pkg;

   // Highest size code the 3-bit size input can carry
   localparam int unsigned SIZE_CODE_MAX = 7;

   // One lookup outcome, registered toward the ports
   typedef struct packed {
      logic valid;
      logic hit;
      logic dirty;
      logic wb;
   } l2t_rsp_t;

   // Address of the first byte above a window, widened by one bit
   function automatic logic [63:0] win_end(input logic [63:0] base, input logic [63:0] bytes);
      return base + bytes;
   endfunction

endpackage

// File: rtl/l2t_addr_split.sv
module l2t_addr_split #(
   parameter int ADDR_W    = 32,
   parameter int OFF_W     = 5,
   parameter int MIN_IDX_W = 5,
   parameter int NSIZES    = 4,
   parameter int TAG_W     = 10,
   parameter int MAX_IDX_W = MIN_IDX_W + NSIZES - 1
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic [2:0]           size_code,
   input  logic [TAG_W-1:0]     vic_tag,
   output logic                 size_on,
   output logic [MAX_IDX_W-1:0] idx,
   output logic [TAG_W-1:0]     tag,
   output logic [ADDR_W-1:0]    vic_addr
);

   logic [MAX_IDX_W-1:0] idx_v [NSIZES];
   logic [TAG_W-1:0]     tag_v [NSIZES];
   logic [ADDR_W-1:0]    vic_v [NSIZES];

   // One field layout per size; the tag slides up with the index width
   for (genvar s = 0; s < NSIZES; s++) begin : g_size
      localparam int IW = MIN_IDX_W + s;
      localparam int TL = OFF_W + IW;
      assign idx_v[s] = MAX_IDX_W'(addr[TL-1:OFF_W]);
      assign tag_v[s] = addr[TL+TAG_W-1:TL];
      assign vic_v[s] = (ADDR_W'(vic_tag) << TL) | (ADDR_W'(idx_v[s]) << OFF_W);
   end

   always_comb begin
      size_on  = 1'b0;
      idx      = '0;
      tag      = '0;
      vic_addr = '0;
      for (int s = 0; s < NSIZES; s++) begin
         if (size_code == 3'(s + 1)) begin
            size_on  = 1'b1;
            idx      = idx_v[s];
            tag      = tag_v[s];
            vic_addr = vic_v[s];
         end
      end
   end

endmodule

// File: rtl/l2t_region_chk.sv
module l2t_region_chk
   import l2t_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] SYS_BASE  = 32'h000F_0000,
   parameter logic [ADDR_W-1:0] SYS_BYTES = 32'h0001_0000,
   parameter logic [ADDR_W-1:0] VID_BASE  = 32'h000C_0000,
   parameter logic [ADDR_W-1:0] VID_BYTES = 32'h0000_8000
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] limit,
   input  logic [1:0]        wp_en,
   output logic              below_limit,
   output logic              prot
);

   localparam int NWIN = 2;
   localparam logic [NWIN-1:0][ADDR_W:0] WIN_LO = {
      {1'b0, VID_BASE}, {1'b0, SYS_BASE}
   };
   localparam logic [NWIN-1:0][ADDR_W:0] WIN_HI = {
      (ADDR_W+1)'(win_end(64'(VID_BASE), 64'(VID_BYTES))),
      (ADDR_W+1)'(win_end(64'(SYS_BASE), 64'(SYS_BYTES)))
   };

   logic [NWIN-1:0] in_win;
   logic [ADDR_W:0] addr_x;

   assign addr_x = {1'b0, addr};

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      assign in_win[w] = (addr_x >= WIN_LO[w]) && (addr_x < WIN_HI[w]);
   end

   assign prot        = |(in_win & wp_en);
   assign below_limit = addr < limit;

endmodule

// File: rtl/l2t_tag_array.sv
module l2t_tag_array #(
   parameter int IDX_W = 8,
   parameter int TAG_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic             rd_dirty,
   output logic [TAG_W-1:0] rd_tag,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_dirty,
   input  logic [TAG_W-1:0] wr_tag
);

   localparam int LINES = 1 << IDX_W;

   logic [LINES-1:0] valid_q;
   logic [LINES-1:0] dirty_q;
   logic [TAG_W-1:0] tag_q [LINES];

   // Only the valid bits need a reset; dirty and tag are qualified by them
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         dirty_q[wr_idx] <= wr_dirty;
         tag_q[wr_idx]   <= wr_tag;
      end
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_dirty = dirty_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];

endmodule

// File: rtl/l2t_ctrl.sv
module l2t_ctrl
   import l2t_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter int                LINE_BYTES = 32,
   parameter int                TAG_W      = 10,
   parameter int                MIN_IDX_W  = 5,
   parameter int                NSIZES     = 4,
   parameter logic [ADDR_W-1:0] SYS_BASE   = 32'h000F_0000,
   parameter logic [ADDR_W-1:0] SYS_BYTES  = 32'h0001_0000,
   parameter logic [ADDR_W-1:0] VID_BASE   = 32'h000C_0000,
   parameter logic [ADDR_W-1:0] VID_BYTES  = 32'h0000_8000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [2:0]        cfg_size,
   input  logic              cfg_wb,
   input  logic [ADDR_W-1:0] cfg_limit,
   input  logic [1:0]        cfg_bios_wp,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_dirty,
   output logic              wb_req,
   output logic [ADDR_W-1:0] wb_addr
);

   localparam int OFF_W     = $clog2(LINE_BYTES);
   localparam int MAX_IDX_W = MIN_IDX_W + NSIZES - 1;

   initial begin
      assert (LINE_BYTES == (1 << OFF_W))
         else $error("line size must be a power of two");
      assert (NSIZES >= 1 && NSIZES <= SIZE_CODE_MAX)
         else $error("size count must fit the 3-bit size code");
      assert (MIN_IDX_W >= 1)
         else $error("index needs at least one bit");
      assert (TAG_W >= 1)
         else $error("tag needs at least one bit");
      assert (ADDR_W >= OFF_W + MAX_IDX_W + TAG_W)
         else $error("address too narrow for the largest size");
   end

   logic                 size_on;
   logic [MAX_IDX_W-1:0] idx;
   logic [TAG_W-1:0]     tag;
   logic [ADDR_W-1:0]    vic_addr;
   logic                 below_limit;
   logic                 prot;
   logic                 line_v;
   logic                 line_d;
   logic [TAG_W-1:0]     line_tag;

   l2t_addr_split #(
      .ADDR_W   (ADDR_W),
      .OFF_W    (OFF_W),
      .MIN_IDX_W(MIN_IDX_W),
      .NSIZES   (NSIZES),
      .TAG_W    (TAG_W),
      .MAX_IDX_W(MAX_IDX_W)
   ) u_split (
      .addr     (req_addr),
      .size_code(cfg_size),
      .vic_tag  (line_tag),
      .size_on  (size_on),
      .idx      (idx),
      .tag      (tag),
      .vic_addr (vic_addr)
   );

   l2t_region_chk #(
      .ADDR_W   (ADDR_W),
      .SYS_BASE (SYS_BASE),
      .SYS_BYTES(SYS_BYTES),
      .VID_BASE (VID_BASE),
      .VID_BYTES(VID_BYTES)
   ) u_region (
      .addr       (req_addr),
      .limit      (cfg_limit),
      .wp_en      (cfg_bios_wp),
      .below_limit(below_limit),
      .prot       (prot)
   );

   logic             upd_en;
   logic             upd_dirty;
   logic [TAG_W-1:0] upd_tag;

   l2t_tag_array #(
      .IDX_W(MAX_IDX_W),
      .TAG_W(TAG_W)
   ) u_tags (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (idx),
      .rd_valid(line_v),
      .rd_dirty(line_d),
      .rd_tag  (line_tag),
      .wr_en   (upd_en),
      .wr_idx  (idx),
      .wr_dirty(upd_dirty),
      .wr_tag  (upd_tag)
   );

   logic     cacheable;
   logic     tag_hit;
   l2t_rsp_t rsp_d;
   l2t_rsp_t rsp_q;
   logic [ADDR_W-1:0] wb_addr_d;

   assign cacheable = size_on && below_limit;
   assign tag_hit   = cacheable && line_v && (line_tag == tag);

   always_comb begin
      rsp_d       = '0;
      wb_addr_d   = '0;
      upd_en      = 1'b0;
      upd_dirty   = 1'b0;
      upd_tag     = tag;
      if (req_valid) begin
         rsp_d.valid = 1'b1;
         rsp_d.hit   = tag_hit;
         rsp_d.dirty = size_on && line_v && line_d;
         if (!req_write) begin
            if (cacheable && !tag_hit) begin
               upd_en   = 1'b1;
               rsp_d.wb = line_v && line_d;
               if (line_v && line_d) begin
                  wb_addr_d = vic_addr;
               end
            end
         end else if (tag_hit && !prot && cfg_wb) begin
            upd_en    = 1'b1;
            upd_dirty = 1'b1;
            upd_tag   = line_tag;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_q   <= '0;
         wb_addr <= '0;
      end else begin
         rsp_q   <= rsp_d;
         wb_addr <= wb_addr_d;
      end
   end

   assign rsp_valid = rsp_q.valid;
   assign rsp_hit   = rsp_q.hit;
   assign rsp_dirty = rsp_q.dirty;
   assign wb_req    = rsp_q.wb;

endmodule

// File: rtl/l2t_ctrl_chk.sv
module l2t_ctrl_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [2:0]        cfg_size,
   input logic [ADDR_W-1:0] cfg_limit,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic              rsp_dirty,
   input logic              wb_req,
   input logic [ADDR_W-1:0] wb_addr
);

   // R2: every request answers in the next cycle
   p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R2: an idle cycle leaves the response quiet
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_hit && !wb_req));

   // R4: a disabled cache never hits and never writes back
   p_off_no_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (cfg_size == 3'd0 || cfg_size > 3'd4)) |=> (!rsp_hit && !wb_req && !rsp_dirty));

   // R5: above the limit nothing is cached
   p_above_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr >= cfg_limit) |=> (!rsp_hit && !wb_req));

   // R7: a writeback only comes from a missed access to a dirty line
   p_wb_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |-> (rsp_valid && !rsp_hit && rsp_dirty));

   // R7: writes never raise a writeback
   p_write_no_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> !wb_req);

   // R7: victim address is zero when no writeback is requested
   p_wb_addr_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wb_req |-> (wb_addr == '0));

endmodule

bind l2t_ctrl l2t_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_write(req_write),
   .req_addr (req_addr),
   .cfg_size (cfg_size),
   .cfg_limit(cfg_limit),
   .rsp_valid(rsp_valid),
   .rsp_hit  (rsp_hit),
   .rsp_dirty(rsp_dirty),
   .wb_req   (wb_req),
   .wb_addr  (wb_addr)
);

// File: tb/l2t_ctrl_tb_top.sv
`timescale 1ns/1ps
module l2t_ctrl_tb_top;

   localparam int MIN_IDX_W = 5;
   localparam int MAXL      = 1 << (MIN_IDX_W + 3);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [2:0]  cfg_size = 3'd1;
   logic        cfg_wb = 1'b1;
   logic [31:0] cfg_limit = 32'h0080_0000;
   logic [1:0]  cfg_bios_wp = 2'b11;
   logic        rsp_valid, rsp_hit, rsp_dirty, wb_req;
   logic [31:0] wb_addr;

   always #4 clk = ~clk;

   l2t_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .cfg_size(cfg_size), .cfg_wb(cfg_wb),
      .cfg_limit(cfg_limit), .cfg_bios_wp(cfg_bios_wp), .rsp_valid(rsp_valid),
      .rsp_hit(rsp_hit), .rsp_dirty(rsp_dirty), .wb_req(wb_req), .wb_addr(wb_addr)
   );

   int  n_chk = 0;
   int  n_fail = 0;
   bit  finished = 0;

   // Reference state built from the requirements
   bit          mv [MAXL];
   bit          md [MAXL];
   logic [9:0]  mt [MAXL];

   logic        o_hit, o_dirty, o_wb;
   logic [31:0] o_wba;

   function automatic bit size_ok(input logic [2:0] s);
      return s >= 3'd1 && s <= 3'd4;
   endfunction

   function automatic int iw(input logic [2:0] s);
      return MIN_IDX_W + int'(s) - 1;
   endfunction

   function automatic int m_idx(input logic [31:0] a, input logic [2:0] s);
      return int'((a >> 5) & ((32'd1 << iw(s)) - 32'd1));
   endfunction

   function automatic logic [9:0] m_tag(input logic [31:0] a, input logic [2:0] s);
      return 10'((a >> (5 + iw(s))) & 32'h3FF);
   endfunction

   function automatic bit m_prot(input logic [31:0] a, input logic [1:0] wp);
      return (wp[0] && a >= 32'hF0000 && a <= 32'hFFFFF) ||
             (wp[1] && a >= 32'hC0000 && a <= 32'hC7FFF);
   endfunction

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", rq, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < MAXL; i++) begin
         mv[i] = 0;
         md[i] = 0;
         mt[i] = '0;
      end
   endtask

   // One access: expectation from the model, drive at negedge, sample next negedge
   task automatic access(input bit w, input logic [31:0] a, input string rq);
      bit          so, cach, e_hit, e_dirty, e_wb;
      logic [31:0] e_wba;
      int          ix;
      logic [9:0]  tg;
      so      = size_ok(cfg_size);
      ix      = so ? m_idx(a, cfg_size) : 0;
      tg      = so ? m_tag(a, cfg_size) : '0;
      cach    = so && (a < cfg_limit);
      e_hit   = cach && mv[ix] && (mt[ix] == tg);
      e_dirty = so && mv[ix] && md[ix];
      e_wb    = 0;
      e_wba   = '0;
      if (!w) begin
         if (cach && !e_hit) begin
            if (mv[ix] && md[ix]) begin
               e_wb  = 1;
               e_wba = (32'(mt[ix]) << (5 + iw(cfg_size))) | (32'(ix) << 5);
            end
            mv[ix] = 1;
            md[ix] = 0;
            mt[ix] = tg;
         end
      end else if (e_hit && !m_prot(a, cfg_bios_wp) && cfg_wb) begin
         md[ix] = 1;
      end
      req_valid = 1'b1;
      req_write = w;
      req_addr  = a;
      @(negedge clk);
      req_valid = 1'b0;
      o_hit = rsp_hit; o_dirty = rsp_dirty; o_wb = wb_req; o_wba = wb_addr;
      chk(rsp_valid === 1'b1, {rq, " R2 rsp_valid"}, 32'(rsp_valid), 32'd1);
      chk(rsp_hit === e_hit, {rq, " hit"}, 32'(rsp_hit), 32'(e_hit));
      chk(rsp_dirty === e_dirty, {rq, " R12 dirty"}, 32'(rsp_dirty), 32'(e_dirty));
      chk(wb_req === e_wb, {rq, " R7 wb_req"}, 32'(wb_req), 32'(e_wb));
      chk(wb_addr === e_wba, {rq, " R7 wb_addr"}, wb_addr, e_wba);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   localparam logic [31:0] A = 32'h0000_0040;
   localparam logic [31:0] B = 32'h0000_0440;
   localparam logic [31:0] C = 32'h0000_0840;

   initial begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'd20240611);

      // R1: reset state
      do_reset();
      chk(rsp_valid === 1'b0 && rsp_hit === 1'b0 && wb_req === 1'b0 && wb_addr === '0,
          "R1 reset outputs", {28'd0, rsp_valid, rsp_hit, wb_req, |wb_addr}, 32'd0);

      // size 1: index bits [9:5], tag bits [19:10]
      access(0, A, "R1 first read");
      chk(o_hit === 1'b0, "R1 first read misses", 32'(o_hit), 0);
      access(0, A, "R6 refill");
      chk(o_hit === 1'b1 && o_dirty === 1'b0, "R6 hit clean", {o_hit, o_dirty}, 32'h2);
      access(1, A, "R8 write hit");
      access(0, A, "R8 read back");
      chk(o_dirty === 1'b1, "R8 dirty set", 32'(o_dirty), 1);
      access(0, B, "R7 evict");
      chk(o_wb === 1'b1 && o_wba === 32'h40, "R7 victim address", o_wba, 32'h40);
      access(0, B, "R6 new tag");
      chk(o_hit === 1'b1 && o_dirty === 1'b0, "R6 new line clean", {o_hit, o_dirty}, 32'h2);
      access(1, C, "R10 write miss");
      access(0, B, "R10 line kept");
      chk(o_hit === 1'b1, "R10 no allocate", 32'(o_hit), 1);
      access(0, B | 32'h0010_0000, "R3 upper bits ignored");
      chk(o_hit === 1'b1, "R3 alias above tag", 32'(o_hit), 1);
      // R2: idle cycle
      @(negedge clk);
      chk(rsp_valid === 1'b0 && rsp_hit === 1'b0, "R2 idle", {rsp_valid, rsp_hit}, 0);
      access(0, 32'h0090_0000, "R5 above limit");
      access(0, 32'h0090_0000, "R5 above limit again");
      chk(o_hit === 1'b0, "R5 never hits", 32'(o_hit), 0);
      access(0, cfg_limit - 32'd32, "R5 just below limit");
      access(0, cfg_limit - 32'd32, "R5 below limit hits");
      chk(o_hit === 1'b1, "R5 boundary cacheable", 32'(o_hit), 1);
      // R11: protected windows
      access(0, 32'h000F_0000, "R11 sys read");
      access(1, 32'h000F_0000, "R11 sys write");
      access(0, 32'h000F_0000, "R11 sys read back");
      chk(o_hit === 1'b1 && o_dirty === 1'b0, "R11 sys stays clean", {o_hit, o_dirty}, 32'h2);
      access(0, 32'h000C_7FE0, "R11 vid read");
      access(1, 32'h000C_7FE0, "R11 vid write");
      access(0, 32'h000C_7FE0, "R11 vid read back");
      chk(o_dirty === 1'b0, "R11 vid stays clean", 32'(o_dirty), 0);

      // R11: window unprotected -> dirtied
      cfg_bios_wp = 2'b00;
      do_reset();
      access(0, 32'h000F_0020, "R11 open read");
      access(1, 32'h000F_0020, "R11 open write");
      access(0, 32'h000F_0020, "R11 open read back");
      chk(o_dirty === 1'b1, "R11 unprotected dirties", 32'(o_dirty), 1);
      cfg_bios_wp = 2'b11;

      // R4: cache off
      for (int code = 0; code < 8; code += 5) begin
         cfg_size = 3'(code);
         do_reset();
         access(0, A, "R4 off read");
         access(0, A, "R4 off read again");
         chk(o_hit === 1'b0, "R4 disabled no hit", 32'(o_hit), 0);
      end

      // R3: size 4 widens the index so A and B no longer conflict
      cfg_size = 3'd4;
      do_reset();
      access(0, A, "R3 fill A");
      access(0, B, "R3 fill B");
      access(0, A, "R3 A kept");
      chk(o_hit === 1'b1, "R3 wide index", 32'(o_hit), 1);
      access(1, A, "R3 dirty A");
      access(0, A | 32'h0080_0000 - 32'h0080_0000 + 32'h0000_2040, "R3 conflict at 8K stride");
      chk(o_wb === 1'b1 && o_wba === 32'h40, "R3 victim with wide index", o_wba, 32'h40);

      // R9: write-through
      cfg_size = 3'd1;
      cfg_wb = 1'b0;
      do_reset();
      access(0, A, "R9 fill");
      access(1, A, "R9 write hit");
      access(0, A, "R9 read back");
      chk(o_hit === 1'b1 && o_dirty === 1'b0, "R9 stays clean", {o_hit, o_dirty}, 32'h2);
      access(0, B, "R9 evict");
      chk(o_wb === 1'b0, "R9 no writeback", 32'(o_wb), 0);

      // Random phases against the model
      for (int ph = 0; ph < 8; ph++) begin
         cfg_size    = 3'($urandom_range(0, 5));
         cfg_wb      = 1'($urandom_range(0, 1));
         cfg_bios_wp = 2'($urandom_range(0, 3));
         case ($urandom_range(0, 2))
            0: cfg_limit = 32'hFFFF_FFFF;
            1: cfg_limit = 32'h0010_0000;
            default: cfg_limit = 32'h0000_8000;
         endcase
         do_reset();
         for (int k = 0; k < 300; k++) begin
            logic [31:0] a;
            case ($urandom_range(0, 5))
               0: a = 32'h000F_0000 | (32'($urandom_range(0, 3)) << 5);
               1: a = 32'h000C_0000 | (32'($urandom_range(0, 3)) << 5);
               2: a = 32'h00F0_0000 | (32'($urandom_range(0, 3)) << 5);
               default: a = (32'($urandom_range(0, 3)) << 15) |
                            (32'($urandom_range(0, 3)) << 5) | 32'($urandom_range(0, 31));
            endcase
            access(1'($urandom_range(0, 1)), a, "R3 random");
         end
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule